// File: doc/BRIEF.md
# ROM/Flash Slave Acknowledge Sequencer

This block sits on a split-transaction processor bus as a target only. It never starts a transfer. For each address tenure that the local decode claims, it decides in which clock the address acknowledge may go out. After that, it paces the data beats of that access to a slow ROM/Flash region. Each beat gets a one-clock data acknowledge, and the spacing between beats depends on the ROM port width, the burst length, the direction and the transfer size.

The rule for the address acknowledge depends on who owns the data tenure that is still running. If nothing is running, the acknowledge goes out in the same clock as the claimed address. If this block is running its own data tenure, the acknowledge goes out together with that tenure's final beat. If another slave owns the tenure, this block waits until the first clock in which the global busy indication is low again.

A claimed address that cannot be acknowledged yet is held in a one-deep slot. Its data phase begins the clock after its acknowledge. The data acknowledges are produced by a down-counter that reloads for every beat.

Top module: `rom_ack_seq`

## Requirements
- R1: After a clock with `rst` high (synchronous, active high), `aack_n`, `ta_n` and `tea_n` are all high and no tenure is in progress.
- R2: When `xfer_start` and `addr_hit` are both high, no own data tenure is running and `bus_dbusy` is low, `aack_n` is low in that same clock.
- R3: A tenure claimed while this block's own data tenure runs gets `aack_n` low exactly in the clock of that tenure's final `ta_n` (or `tea_n`) pulse, and not earlier.
- R4: A tenure claimed while another slave's tenure is running (`bus_dbusy` high, no own tenure) keeps `aack_n` high and drives it low in the first clock where `bus_dbusy` is low.
- R5: With `rom_wide`=1 (64-bit port), a 4-beat read (`burst`=1, `write`=0) gives `ta_n` pulses 13, 20, 27 and 34 clocks after the acknowledge clock.
- R6: With `rom_wide`=0 (16-bit port), a 4-beat read gives `ta_n` pulses 34, 62, 90 and 118 clocks after the acknowledge clock.
- R7: A single-beat read with `xfer_size`=0 (one byte; the field encodes bytes minus one) gives one `ta_n` pulse after 13 clocks at either width. Sizes 1 to 7 give 13 clocks with `rom_wide`=1 and 34 clocks with `rom_wide`=0.
- R8: A single-beat write gives one `ta_n` pulse 21 clocks after the acknowledge clock at either width.
- R9: A 4-beat write with `rom_wide`=1 gives `ta_n` pulses 13, 26, 39 and 52 clocks after the acknowledge clock.
- R10: A 4-beat write with `rom_wide`=0 gives one `tea_n` pulse 1 clock after the acknowledge clock and no `ta_n`. The block is then idle, and a following claim is acknowledged at once.
- R11: `ta_n` and `tea_n` are never low together and each low pulse lasts one clock. `aack_n` stays high when no claimed tenure is pending (for example `xfer_start` without `addr_hit`).
- R12: A tenure acknowledged together with a final beat starts its data phase in the next clock, and its beat offsets are counted from its own acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_start | input | 1 | Address tenure starts this clock |
| addr_hit | input | 1 | Address decodes to the ROM/Flash region |
| burst | input | 1 | 1 = 4-beat transfer, 0 = single beat |
| xfer_size | input | 3 | Bytes minus one for single-beat transfers |
| write | input | 1 | 1 = write, 0 = read |
| rom_wide | input | 1 | 1 = 64-bit ROM port, 0 = 16-bit ROM port |
| bus_dbusy | input | 1 | Some data tenure is in progress on the bus (low from the clock after its final beat) |
| aack_n | output | 1 | Address acknowledge, active low |
| ta_n | output | 1 | Data beat acknowledge, active low, one clock per beat |
| tea_n | output | 1 | Transfer error acknowledge, active low |

## Verification
If the beat counter or the remaining-beat count is wrong, the `ta_n` pulses move away from their expected offsets, or a beat is missing or extra. This shows up within one beat period, at most 34 clocks. If the ownership or pending state is wrong, `aack_n` is low in a clock where the running tenure has no final beat, or while a foreign tenure is still busy, or a claim is never acknowledged. These faults are visible in the clock where the acknowledge should or should not appear. A lost held request shows up as a missing acknowledge at the next final beat.

// File: rtl/rom_ack_pkg.sv
`timescale 1ns/1ps
package rom_ack_pkg;

  typedef struct packed {
    logic       burst;
    logic [2:0] sz;
    logic       wr;
    logic       wide;
  } acc_t;

  typedef struct packed {
    int unsigned wide_first;
    int unsigned wide_next;
    int unsigned narrow_first;
    int unsigned narrow_next;
    int unsigned byte_rd;
    int unsigned single_wr;
    int unsigned burst_wr;
  } lat_t;

  // An access the ROM port cannot carry: a burst write to the narrow port.
  function automatic logic acc_bad(acc_t a);
    return a.burst && a.wr && !a.wide;
  endfunction

  // Clocks from the acknowledge clock (or from the previous beat) to the first beat.
  function automatic int unsigned lat_first(acc_t a, lat_t l);
    if (a.wr)              return a.burst ? l.burst_wr : l.single_wr;
    if (!a.burst && a.sz == 3'd0) return l.byte_rd;
    return a.wide ? l.wide_first : l.narrow_first;
  endfunction

  // Clocks between later beats of a burst.
  function automatic int unsigned lat_next(acc_t a, lat_t l);
    if (a.wr) return l.burst_wr;
    return a.wide ? l.wide_next : l.narrow_next;
  endfunction

endpackage

// File: rtl/aack_gate.sv
`timescale 1ns/1ps
module aack_gate
  import rom_ack_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  input  acc_t acc_in,
  input  logic bus_dbusy,
  input  logic eng_busy,
  input  logic eng_last,
  output logic aack,
  output logic req_pend,
  output acc_t acc_out
);

  logic held;
  acc_t held_acc;
  logic may_ack;

  always_comb begin
    req_pend = held | req_in;
    acc_out  = held ? held_acc : acc_in;
    // Own tenure: acknowledge rides on its final beat; foreign: wait for bus idle.
    may_ack  = eng_busy ? eng_last : !bus_dbusy;
    aack     = req_pend & may_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      held_acc <= '0;
    end else if (aack) begin
      held     <= 1'b0;
    end else if (req_in && !held) begin
      held     <= 1'b1;
      held_acc <= acc_in;
    end
  end

endmodule

// File: rtl/beat_engine.sv
`timescale 1ns/1ps
module beat_engine
  import rom_ack_pkg::*;
#(
  parameter int   CNT_W = 7,
  parameter int   BEATS = 4,
  parameter lat_t LAT   = '{13, 7, 34, 28, 13, 21, 13}
)(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  acc_t acc,
  output logic ta,
  output logic tea,
  output logic busy,
  output logic last
);

  localparam int LEFT_W = (BEATS > 2) ? $clog2(BEATS) : 1;

  logic [CNT_W-1:0]  cnt;
  logic [LEFT_W-1:0] left;
  logic              err;
  acc_t              acc_q;
  logic              fire;

  always_comb begin
    fire = busy && (cnt == '0);
    ta   = fire && !err;
    tea  = fire && err;
    last = fire && (err || left == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      left  <= '0;
      err   <= 1'b0;
      acc_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      acc_q <= acc;
      err   <= acc_bad(acc);
      cnt   <= acc_bad(acc) ? '0 : CNT_W'(lat_first(acc, LAT) - 1);
      left  <= acc.burst ? LEFT_W'(BEATS - 1) : '0;
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        left <= left - 1'b1;
        cnt  <= CNT_W'(lat_next(acc_q, LAT) - 1);
      end
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rom_ack_seq.sv
`timescale 1ns/1ps
module rom_ack_seq
  import rom_ack_pkg::*;
#(
  parameter int CNT_W        = 7,
  parameter int BEATS        = 4,
  parameter int WIDE_FIRST   = 13,
  parameter int WIDE_NEXT    = 7,
  parameter int NARROW_FIRST = 34,
  parameter int NARROW_NEXT  = 28,
  parameter int BYTE_RD      = 13,
  parameter int SINGLE_WR    = 21,
  parameter int BURST_WR     = 13
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       xfer_start,
  input  logic       addr_hit,
  input  logic       burst,
  input  logic [2:0] xfer_size,
  input  logic       write,
  input  logic       rom_wide,
  input  logic       bus_dbusy,
  output logic       aack_n,
  output logic       ta_n,
  output logic       tea_n
);

  localparam lat_t LAT = '{WIDE_FIRST, WIDE_NEXT, NARROW_FIRST, NARROW_NEXT,
                           BYTE_RD, SINGLE_WR, BURST_WR};

  acc_t acc_in, acc_go;
  logic claim, aack, req_v;
  logic eng_busy, eng_last, ta, tea;

  assign claim  = xfer_start & addr_hit;
  assign acc_in = '{burst: burst, sz: xfer_size, wr: write, wide: rom_wide};

  aack_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .req_in   (claim),
    .acc_in   (acc_in),
    .bus_dbusy(bus_dbusy),
    .eng_busy (eng_busy),
    .eng_last (eng_last),
    .aack     (aack),
    .req_pend (req_v),
    .acc_out  (acc_go)
  );

  beat_engine #(.CNT_W(CNT_W), .BEATS(BEATS), .LAT(LAT)) u_eng (
    .clk (clk),
    .rst (rst),
    .load(aack),
    .acc (acc_go),
    .ta  (ta),
    .tea (tea),
    .busy(eng_busy),
    .last(eng_last)
  );

  assign aack_n = ~aack;
  assign ta_n   = ~ta;
  assign tea_n  = ~tea;

endmodule

// File: rtl/rom_ack_chk.sv
`timescale 1ns/1ps
module rom_ack_chk (
  input logic clk,
  input logic rst,
  input logic aack_n,
  input logic ta_n,
  input logic tea_n,
  input logic req_v,
  input logic eng_busy,
  input logic eng_last,
  input logic bus_dbusy
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (ta_n && tea_n)); // R1
  AST_IMMEDIATE_ACK: assert property (@(posedge clk) disable iff (rst)
    (req_v && !eng_busy && !bus_dbusy) |-> !aack_n); // R2
  AST_OWN_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    (!aack_n && eng_busy) |-> eng_last); // R3
  AST_FOREIGN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!aack_n && !eng_busy) |-> !bus_dbusy); // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tea_n |=> (ta_n && tea_n)); // R10
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!ta_n && !tea_n)); // R11
  AST_TA_PULSE: assert property (@(posedge clk) disable iff (rst)
    !ta_n |=> ta_n); // R11
  AST_NO_SPURIOUS_AACK: assert property (@(posedge clk) disable iff (rst)
    !aack_n |-> req_v); // R11

endmodule

bind rom_ack_seq rom_ack_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .aack_n   (aack_n),
  .ta_n     (ta_n),
  .tea_n    (tea_n),
  .req_v    (req_v),
  .eng_busy (eng_busy),
  .eng_last (eng_last),
  .bus_dbusy(bus_dbusy)
);

// File: tb/test_rom_ack_seq.sv
`timescale 1ns/1ps
module test_rom_ack_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xfer_start = 1'b0, addr_hit = 1'b0, burst = 1'b0, write = 1'b0;
  logic       rom_wide = 1'b1, bus_dbusy = 1'b0;
  logic [2:0] xfer_size = 3'd0;
  logic       aack_n, ta_n, tea_n;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rom_ack_seq i_rom_ack_seq (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .addr_hit(addr_hit),
    .burst(burst), .xfer_size(xfer_size), .write(write), .rom_wide(rom_wide),
    .bus_dbusy(bus_dbusy), .aack_n(aack_n), .ta_n(ta_n), .tea_n(tea_n)
  );

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Beat spacing restated from the requirements as (first, gap) pairs.
  function automatic int gap0(bit wide, bit bu, bit [2:0] sz, bit wr);
    if (wr && bu) return 13;
    if (wr) return 21;
    if (bu) return wide ? 13 : 34;
    return (sz == 3'd0 || wide) ? 13 : 34;
  endfunction
  function automatic int gapn(bit wide, bit wr);
    return wr ? 13 : (wide ? 7 : 28);
  endfunction
  function automatic string tag(bit wide, bit bu, bit wr);
    if (bu && wr) return wide ? "R9" : "R10";
    if (wr) return "R8";
    if (bu) return wide ? "R5" : "R6";
    return "R7";
  endfunction

  task automatic run_one(input bit wide, input bit bu, input bit [2:0] sz, input bit wr);
    int nb, got, lim, f, g;
    bit err;
    string t;
    err = bu && wr && !wide;
    nb  = err ? 0 : (bu ? 4 : 1);
    f   = gap0(wide, bu, sz, wr);
    g   = gapn(wide, wr);
    t   = tag(wide, bu, wr);
    lim = err ? 40 : f + (nb - 1) * g + 3;
    got = 0;
    step();
    xfer_start = 1; addr_hit = 1; burst = bu; xfer_size = sz; write = wr; rom_wide = wide;
    #1 chk(aack_n == 1'b0, "R2", aack_n, 0);
    for (int off = 1; off <= lim; off++) begin
      step();
      if (off == 1) begin xfer_start = 0; addr_hit = 0; end
      #1;
      if (err) begin
        if (off == 1) chk(tea_n == 1'b0, t, tea_n, 0);
        else if (tea_n == 1'b0) chk(0, t, off, 1);
      end else if (tea_n == 1'b0) chk(0, t, off, -1);
      if (ta_n == 1'b0) begin
        if (got < nb) chk(off == f + got * g, t, off, f + got * g);
        got++;
      end
    end
    chk(got == nb, t, got, nb);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step();
    #1 chk(aack_n && ta_n && tea_n, "R1", {aack_n, ta_n, tea_n}, 7);
    rst = 0;
    step();
    xfer_start = 1; addr_hit = 0;
    #1 chk(aack_n == 1'b1, "R11", aack_n, 1);
    step();
    xfer_start = 0;
    #1 chk(aack_n && ta_n && tea_n, "R1", {aack_n, ta_n, tea_n}, 7);

    run_one(1, 1, 3'd7, 0);  // R5
    run_one(0, 1, 3'd7, 0);  // R6
    run_one(1, 0, 3'd0, 0);  // R7 byte, wide
    run_one(0, 0, 3'd0, 0);  // R7 byte, narrow
    run_one(0, 0, 3'd3, 0);  // R7 multi-byte, narrow
    run_one(1, 0, 3'd7, 0);  // R7 multi-byte, wide
    run_one(0, 0, 3'd1, 1);  // R8
    run_one(1, 1, 3'd7, 1);  // R9
    run_one(0, 1, 3'd7, 1);  // R10
    run_one(1, 0, 3'd0, 0);  // R10: idle again, immediate aack

    // R3 / R12: second claim while own single byte read is running.
    step();
    xfer_start = 1; addr_hit = 1; burst = 0; xfer_size = 0; write = 0; rom_wide = 1;
    #1 chk(aack_n == 1'b0, "R2", aack_n, 0);
    for (int off = 1; off <= 37; off++) begin
      step();
      xfer_start = (off == 5); addr_hit = (off == 5);
      burst = 0; write = (off == 5); rom_wide = 1; xfer_size = 3'd2;
      #1;
      if (off >= 5 && off < 13) begin if (aack_n != 1'b1) chk(0, "R3", aack_n, 1); end
      if (off == 13) chk(aack_n == 1'b0 && ta_n == 1'b0, "R3", {aack_n, ta_n}, 0);
      if (off == 34) chk(ta_n == 1'b0, "R12", ta_n, 0);
      else if (off != 13 && ta_n == 1'b0) chk(0, "R12", off, 34);
    end

    // R4: foreign tenure in progress.
    step();
    bus_dbusy = 1; xfer_start = 1; addr_hit = 1; burst = 0; xfer_size = 0; write = 0;
    #1 chk(aack_n == 1'b1, "R4", aack_n, 1);
    for (int off = 1; off <= 20; off++) begin
      step();
      xfer_start = 0; addr_hit = 0;
      bus_dbusy = (off < 5);
      #1;
      if (off < 5 && aack_n == 1'b0) chk(0, "R4", off, 5);
      if (off == 5) chk(aack_n == 1'b0, "R4", aack_n, 0);
      if (off == 18) chk(ta_n == 1'b0, "R4", ta_n, 0);
    end

    // Constrained random mix.
    for (int i = 0; i < 30; i++) begin
      run_one(1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule